// File: doc/BRIEF.md
# NAND-Style ROM Read Sequencer

A synthesizable target-side model of a read-only page memory reached through a byte-wide, NAND-like control interface. All interface pins are sampled on the system clock. A command byte and a three-byte address are latched on rising write-strobe edges. After a page-load wait, each falling read-strobe edge presents the next byte on an 8-bit output. An active-low flag reports when the block is busy.

A page holds 528 bytes: 512 data bytes followed by 16 spare bytes. Pages are grouped 32 to a block, and there are 1024 blocks. Three read commands pick where in the page the start column falls:

- the lower half of the data area,
- the upper half of the data area,
- the spare area.

A fourth command restarts the block. Reading past the last column of a page loads the next page of the same block after a busy wait, and reading resumes at the first column of the region that the command selected. Array contents come from a fixed function of page and column. Spare bytes always read as FFh.

Top module: `nand_rom_reader`

## Requirements
- R1: After `rst_n` is released, `busy_n` is 1 and `io_out` is 00h, and falling `re_n` edges leave `io_out` unchanged.
- R2: A command cycle (`cle`=1, `ale`=0) or an address cycle (`ale`=1, `cle`=0) is taken only on a rising `we_n` edge while `ce_n` is 0. Strobes made with `ce_n` at 1 start nothing.
- R3: Command 00h starts at column N, where N is address byte 1 (0..255). The page number is {byte3[6:0], byte2[7:0]}, and bit 7 of byte 3 is ignored.
- R4: Command 01h starts at column 256+N, with the page number formed as in R3.
- R5: Command 50h starts at column 512+byte1[3:0], and bits 7..4 of byte 1 are ignored. Every column from 512 to 527 reads FFh in every mode.
- R6: The third address cycle makes `busy_n` 0 for exactly LOAD_CYC clocks, after which it returns to 1. `io_out` does not change while `busy_n` is 0.
- R7: Each falling `re_n` edge seen while streaming puts the byte at the current column on `io_out` at that clock edge, then advances the column. For a column c below 512 on page p, the byte is c[7:0] ^ p[7:0] ^ {p[14:8], c[8]}.
- R8: After column 527 of a page whose low five page bits are not all ones, with `ce_n` held 0, the block waits GRACE_CYC clocks. It then goes busy for LOAD_CYC clocks and resumes at page+1. The resume column is 0 for commands 00h and 01h, and 512 for command 50h.
- R9: After column 527 of the last page of a block (low five page bits all ones), the read ends. `busy_n` stays 1, and further `re_n` edges leave `io_out` unchanged.
- R10: `ce_n` at 1 ends a read in progress, and later `re_n` edges leave `io_out` unchanged. If `ce_n` rises within GRACE_CYC clocks after column 527 has been read, no busy period starts.
- R11: Command FFh is taken at any time, including while busy. It makes `busy_n` 0 for exactly RST_CYC clocks and leaves no read command pending, so address cycles that follow start nothing.
- R12: While busy, commands other than FFh and all address cycles are ignored. Command bytes other than 00h, 01h, 50h and FFh are ignored in every state. Address cycles with no read command pending start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Device select, active low |
| cle | input | 1 | Marks the current write cycle as a command byte |
| ale | input | 1 | Marks the current write cycle as an address byte |
| we_n | input | 1 | Write strobe; a byte is taken on its rising edge |
| re_n | input | 1 | Read strobe; each falling edge yields one byte |
| io_in | input | 8 | Command and address byte |
| io_out | output | 8 | Last byte read from the array |
| busy_n | output | 1 | 1 when ready, 0 during page load or restart |

## Verification
A wrong column pointer shows up on the very next `re_n` fall, because the byte function mixes every column and page bit into the output. A wrong page register first shows on the first byte after a page wrap. A wrong state or counter shows at `busy_n`: either a busy period whose length differs by even one clock from LOAD_CYC or RST_CYC, or a busy period that appears where R9, R10 or R12 forbid one. Ignored stimulus is checked by reading the next byte and confirming that the stream continues where the reference model says it should.

// File: rtl/nrs_pkg.sv
package nrs_pkg;
  localparam int MAIN_BYTES  = 512;
  localparam int SPARE_BYTES = 16;
  localparam int PAGE_BYTES  = MAIN_BYTES + SPARE_BYTES;
  localparam int HALF_BYTES  = MAIN_BYTES / 2;
  localparam int COL_W       = $clog2(PAGE_BYTES);
  localparam int SP_W        = $clog2(SPARE_BYTES);
  localparam int PG_W        = 15;
  localparam int BLK_PG_W    = 5;
  localparam int ADDR_CYCLES = 3;

  typedef logic [COL_W-1:0] col_t;
  typedef logic [PG_W-1:0]  pg_t;

  localparam col_t COL_LAST = col_t'(PAGE_BYTES - 1);

  typedef enum logic [1:0] {
    RM_LOW   = 2'd0,
    RM_HIGH  = 2'd1,
    RM_SPARE = 2'd2,
    RM_NONE  = 2'd3
  } rmode_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ADDR   = 3'd1,
    ST_LOAD   = 3'd2,
    ST_STREAM = 3'd3,
    ST_GRACE  = 3'd4,
    ST_RST    = 3'd5
  } st_t;

  localparam logic [7:0] OP_LOW   = 8'h00;
  localparam logic [7:0] OP_HIGH  = 8'h01;
  localparam logic [7:0] OP_SPARE = 8'h50;
  localparam logic [7:0] OP_RST   = 8'hFF;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic logic is_read_op(input logic [7:0] op);
    return (op == OP_LOW) || (op == OP_HIGH) || (op == OP_SPARE);
  endfunction

  function automatic rmode_t op_mode(input logic [7:0] op);
    case (op)
      OP_LOW:   return RM_LOW;
      OP_HIGH:  return RM_HIGH;
      OP_SPARE: return RM_SPARE;
      default:  return RM_NONE;
    endcase
  endfunction

  // column at which a freshly addressed read begins
  function automatic col_t start_col(input rmode_t m, input logic [7:0] b1);
    case (m)
      RM_LOW:   return col_t'(b1);
      RM_HIGH:  return col_t'(HALF_BYTES) + col_t'(b1);
      RM_SPARE: return col_t'(MAIN_BYTES) + col_t'(b1[SP_W-1:0]);
      default:  return '0;
    endcase
  endfunction

  // column at which the next page of a sequential read resumes
  function automatic col_t region_start(input rmode_t m);
    return (m == RM_SPARE) ? col_t'(MAIN_BYTES) : '0;
  endfunction

  function automatic logic block_end(input pg_t p);
    return &p[BLK_PG_W-1:0];
  endfunction

  // array content: spare area fixed, data area derived from address bits
  function automatic logic [7:0] cell_byte(input pg_t p, input col_t c);
    if (c >= col_t'(MAIN_BYTES)) return 8'hFF;
    return c[7:0] ^ p[7:0] ^ {p[PG_W-1:8], c[8]};
  endfunction
endpackage

// File: rtl/nrs_bus_decode.sv
module nrs_bus_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic cle,
  input  logic ale,
  input  logic we_n,
  input  logic re_n,
  output logic cmd_stb,
  output logic addr_stb,
  output logic rd_stb
);
  logic we_q;
  logic re_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      re_q <= 1'b1;
    end else begin
      we_q <= we_n;
      re_q <= re_n;
    end
  end

  logic we_rise;
  logic re_fall;
  assign we_rise = we_n & ~we_q;
  assign re_fall = ~re_n & re_q;

  assign cmd_stb  = ~ce_n & we_rise &  cle & ~ale;
  assign addr_stb = ~ce_n & we_rise &  ale & ~cle;
  assign rd_stb   = ~ce_n & re_fall;
endmodule

// File: rtl/nrs_addr_latch.sv
module nrs_addr_latch
  import nrs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       stb,
  input  logic [7:0] din,
  output logic       done,
  output pg_t        pg_out,
  output logic [7:0] col_byte
);
  localparam int IDX_W = $clog2(ADDR_CYCLES);
  typedef logic [IDX_W-1:0] idx_t;
  localparam idx_t IDX_LAST = idx_t'(ADDR_CYCLES - 1);

  idx_t       idx;
  logic [7:0] byte_q [ADDR_CYCLES-1];

  assign done = stb && (idx == IDX_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (clr || done) begin
      idx <= '0;
    end else if (stb) begin
      idx <= idx + idx_t'(1);
    end
  end

  for (genvar g = 0; g < ADDR_CYCLES - 1; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q[g] <= '0;
      else if (stb && (idx == idx_t'(g))) byte_q[g] <= din;
    end
  end

  logic unused_top_bit;
  assign unused_top_bit = din[7];

  assign pg_out   = {din[PG_W-9:0], byte_q[1]};
  assign col_byte = byte_q[0];
endmodule

// File: rtl/nrs_read_fsm.sv
module nrs_read_fsm
  import nrs_pkg::*;
#(
  parameter int LOAD_CYC  = 24,
  parameter int RST_CYC   = 16,
  parameter int GRACE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cmd_stb,
  input  logic [7:0] din,
  input  logic       addr_done,
  input  pg_t        pg_in,
  input  logic [7:0] c1_in,
  input  logic       rd_stb,
  output st_t        st_o,
  output col_t       col_o,
  output logic [7:0] dout,
  output logic       busy_n,
  output logic       cmd_take,
  output logic       addr_open
);
  localparam int CNT_MAX = max3(LOAD_CYC, RST_CYC, GRACE_CYC);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  typedef logic [CNT_W-1:0] cnt_t;

  st_t        st;
  cnt_t       cnt;
  rmode_t     mode_q;
  pg_t        pg_q;
  col_t       col_q;
  logic [7:0] dout_q;

  logic busy_now;
  logic rst_cmd;
  assign busy_now  = (st == ST_LOAD) || (st == ST_RST);
  assign rst_cmd   = cmd_stb && (din == OP_RST);
  assign cmd_take  = cmd_stb && is_read_op(din) && !busy_now;
  assign addr_open = (st == ST_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      mode_q <= RM_NONE;
      pg_q   <= '0;
      col_q  <= '0;
      dout_q <= '0;
    end else if (rst_cmd) begin
      st     <= ST_RST;
      cnt    <= cnt_t'(RST_CYC - 1);
      mode_q <= RM_NONE;
    end else begin
      case (st)
        ST_RST: begin
          if (cnt == '0) st <= ST_IDLE;
          else cnt <= cnt - cnt_t'(1);
        end
        ST_LOAD: begin
          if (cnt == '0) st <= ST_STREAM;
          else cnt <= cnt - cnt_t'(1);
        end
        default: begin
          if (cmd_take) begin
            st     <= ST_ADDR;
            mode_q <= op_mode(din);
          end else begin
            case (st)
              ST_ADDR: begin
                if (addr_done) begin
                  pg_q  <= pg_in;
                  col_q <= start_col(mode_q, c1_in);
                  st    <= ST_LOAD;
                  cnt   <= cnt_t'(LOAD_CYC - 1);
                end
              end
              ST_STREAM: begin
                if (ce_n) begin
                  st <= ST_IDLE;
                end else if (rd_stb) begin
                  dout_q <= cell_byte(pg_q, col_q);
                  if (col_q == COL_LAST) begin
                    if (block_end(pg_q)) begin
                      st <= ST_IDLE;
                    end else begin
                      st  <= ST_GRACE;
                      cnt <= cnt_t'(GRACE_CYC - 1);
                    end
                  end else begin
                    col_q <= col_q + col_t'(1);
                  end
                end
              end
              ST_GRACE: begin
                if (ce_n) begin
                  st <= ST_IDLE;
                end else if (cnt == '0) begin
                  st    <= ST_LOAD;
                  cnt   <= cnt_t'(LOAD_CYC - 1);
                  pg_q  <= pg_q + pg_t'(1);
                  col_q <= region_start(mode_q);
                end else begin
                  cnt <= cnt - cnt_t'(1);
                end
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  assign st_o   = st;
  assign col_o  = col_q;
  assign dout   = dout_q;
  assign busy_n = !busy_now;
endmodule

// File: rtl/nand_rom_reader.sv
module nand_rom_reader
  import nrs_pkg::*;
#(
  parameter int LOAD_CYC  = 24,
  parameter int RST_CYC   = 16,
  parameter int GRACE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic [7:0] io_in,
  output logic [7:0] io_out,
  output logic       busy_n
);
  logic       cmd_stb;
  logic       addr_stb;
  logic       rd_stb;
  logic       addr_done;
  logic       cmd_take;
  logic       addr_open;
  pg_t        pg_lat;
  logic [7:0] c1_lat;
  st_t        st;
  col_t       col;

  nrs_bus_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .cle      (cle),
    .ale      (ale),
    .we_n     (we_n),
    .re_n     (re_n),
    .cmd_stb  (cmd_stb),
    .addr_stb (addr_stb),
    .rd_stb   (rd_stb)
  );

  nrs_addr_latch u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cmd_take),
    .stb      (addr_stb && addr_open),
    .din      (io_in),
    .done     (addr_done),
    .pg_out   (pg_lat),
    .col_byte (c1_lat)
  );

  nrs_read_fsm #(
    .LOAD_CYC  (LOAD_CYC),
    .RST_CYC   (RST_CYC),
    .GRACE_CYC (GRACE_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .cmd_stb   (cmd_stb),
    .din       (io_in),
    .addr_done (addr_done),
    .pg_in     (pg_lat),
    .c1_in     (c1_lat),
    .rd_stb    (rd_stb),
    .st_o      (st),
    .col_o     (col),
    .dout      (io_out),
    .busy_n    (busy_n),
    .cmd_take  (cmd_take),
    .addr_open (addr_open)
  );
endmodule

// File: rtl/nrs_checker.sv
module nrs_checker
  import nrs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic [7:0] io_in,
  input logic [7:0] io_out,
  input logic       busy_n,
  input logic       cmd_stb,
  input logic       rd_stb,
  input logic       addr_done,
  input st_t        st,
  input col_t       col
);
  a_r6_busy_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done |=> !busy_n);

  a_r6_dout_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |=> $stable(io_out));

  a_r11_reset_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && io_in == OP_RST) |=> !busy_n);

  a_r5_spare_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && st == ST_STREAM && col >= col_t'(MAIN_BYTES)) |=> io_out == 8'hFF);

  a_r10_ce_ends_read: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && (st == ST_STREAM || st == ST_GRACE)) |=> st == ST_IDLE);

  a_r9_idle_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && st == ST_IDLE) |=> $stable(io_out));

  a_r8_col_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    col <= COL_LAST);
endmodule

bind nand_rom_reader nrs_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .io_in     (io_in),
  .io_out    (io_out),
  .busy_n    (busy_n),
  .cmd_stb   (cmd_stb),
  .rd_stb    (rd_stb),
  .addr_done (addr_done),
  .st        (st),
  .col       (col)
);

// File: tb/tb_nand_rom_reader.sv
module tb_nand_rom_reader;
  localparam int LOAD  = 24;
  localparam int RSTC  = 16;
  localparam int GRACE = 4;
  localparam int LASTC = 527;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       ce_n = 1, cle = 0, ale = 0, we_n = 1, re_n = 1;
  logic [7:0] io_in = 0;
  logic [7:0] io_out;
  logic       busy_n;

  int  n_chk = 0, n_bad = 0;
  bit  finished = 0;

  always #2 clk = ~clk;

  nand_rom_reader #(.LOAD_CYC(LOAD), .RST_CYC(RSTC), .GRACE_CYC(GRACE)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .io_in(io_in), .io_out(io_out), .busy_n(busy_n));

  // reference model of array content
  function automatic int exp_byte(input int pg, input int col);
    int hi;
    if (col >= 512) return 255;
    hi = ((pg / 256) % 128) * 2 + ((col / 256) % 2);
    return ((col % 256) ^ (pg % 256) ^ hi) & 255;
  endfunction

  function automatic int first_col(input int op, input int c1);
    if (op == 8'h00) return c1;
    if (op == 8'h01) return 256 + c1;
    return 512 + (c1 % 16);
  endfunction

  function automatic int wrap_col(input int op);
    return (op == 8'h50) ? 512 : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bus_write(input bit is_cmd, input int b);
    @(negedge clk); cle = is_cmd; ale = !is_cmd; io_in = 8'(b); we_n = 0;
    @(negedge clk); we_n = 1;
    @(negedge clk); cle = 0; ale = 0;
  endtask

  task automatic issue_read(input int op, input int c1, input int c2, input int c3);
    bus_write(1, op);
    bus_write(0, c1);
    bus_write(0, c2);
    bus_write(0, c3);
  endtask

  task automatic read_byte(output int v);
    @(negedge clk) re_n = 0;
    @(negedge clk) begin v = int'(io_out); re_n = 1; end
    @(negedge clk);
  endtask

  task automatic measure_busy(output int n);
    int g = 0;
    n = 0;
    while (busy_n && g < 64) begin g++; @(negedge clk); end
    while (!busy_n && n < 100000) begin n++; @(negedge clk); end
  endtask

  task automatic hold_ready(input int k, output int n);
    n = 0;
    repeat (k) begin @(negedge clk); if (!busy_n) n++; end
  endtask

  task automatic end_read();
    @(negedge clk) ce_n = 1;
    @(negedge clk);
    @(negedge clk) ce_n = 0;
  endtask

  // reads nreads bytes following the model, checking wraps and block end
  task automatic run_stream(input int op, inout int pg, inout int col,
                            input int nreads, output bit ended);
    int v, n;
    string tag;
    ended = 0;
    for (int i = 0; i < nreads; i++) begin
      read_byte(v);
      tag = (col >= 512) ? "R5" : "R7";
      chk(tag, v, exp_byte(pg, col));
      if (col == LASTC) begin
        if ((pg % 32) == 31) begin
          hold_ready(GRACE + LOAD + 2, n);
          chk("R9", n, 0);
          ended = 1;
          break;
        end
        measure_busy(n);
        chk("R8", n, LOAD);
        pg++;
        col = wrap_col(op);
      end else begin
        col++;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, n, pg, col, op, c1, c2, c3, sel, prev;
    bit ended;
    int seed;
    seed = 32'h5EED1234;
    v = $urandom(seed);

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    ce_n = 0;
    // R1: reset state
    chk("R1", busy_n, 1);
    chk("R1", io_out, 0);
    read_byte(v);
    chk("R1", v, 0);

    // R12: address cycles with nothing pending
    bus_write(0, 8'h12); bus_write(0, 8'h34); bus_write(0, 8'h01);
    hold_ready(LOAD + 4, n);
    chk("R12", n, 0);
    read_byte(v);
    chk("R12", v, 0);

    // R2: strobes with device deselected
    ce_n = 1;
    issue_read(8'h00, 8'h10, 8'h20, 8'h01);
    hold_ready(LOAD + 4, n);
    chk("R2", n, 0);
    ce_n = 0;
    read_byte(v);
    chk("R2", v, 0);

    // R3 + R6 + R8: mode 00h, byte 3 bit 7 set, run across page end
    issue_read(8'h00, 8'hFE, 8'h37, 8'h85);
    pg = 16'h0537; col = first_col(8'h00, 8'hFE);
    measure_busy(n);
    chk("R6", n, LOAD);
    read_byte(v);
    chk("R3", v, exp_byte(pg, col));
    col++;
    run_stream(8'h00, pg, col, 276, ended);

    // R12: unknown command while streaming has no effect
    bus_write(1, 8'h3C);
    read_byte(v);
    chk("R12", v, exp_byte(pg, col));
    col++;
    end_read();

    // R4 + R12: read command and address during busy are ignored
    issue_read(8'h01, 8'h10, 8'h42, 8'h07);
    pg = (7 << 8) | 8'h42; col = first_col(8'h01, 8'h10);
    bus_write(1, 8'h50);
    bus_write(0, 8'h22);
    measure_busy(n);
    read_byte(v);
    chk("R4", v, exp_byte(pg, col));
    col++;
    read_byte(v);
    chk("R12", v, exp_byte(pg, col));
    end_read();

    // R5 + R8: spare mode, upper nibble ignored, wraps to column 512
    issue_read(8'h50, 8'hFE, 8'h61, 8'h10);
    pg = (8'h10 << 8) | 8'h61; col = first_col(8'h50, 8'hFE);
    chk("R5", col, 526);
    measure_busy(n);
    chk("R6", n, LOAD);
    run_stream(8'h50, pg, col, 19, ended);
    chk("R8", col, 513);
    end_read();

    // R9: last page of block ends the read
    issue_read(8'h00, 8'hF0, 8'h9F, 8'h33);
    pg = (8'h33 << 8) | 8'h9F; col = 240;
    measure_busy(n);
    run_stream(8'h00, pg, col, 300, ended);
    chk("R9", ended, 1);
    read_byte(v);
    chk("R9", v, 255);
    end_read();

    // R10: CE high right after last byte of page cancels the load
    issue_read(8'h01, 8'hFD, 8'h44, 8'h01);
    pg = (1 << 8) | 8'h44; col = 509;
    measure_busy(n);
    run_stream(8'h01, pg, col, 18, ended);
    read_byte(v);
    chk("R10", v, 255);
    ce_n = 1;
    hold_ready(LOAD + GRACE + 4, n);
    chk("R10", n, 0);
    ce_n = 0;
    hold_ready(LOAD + GRACE + 4, n);
    chk("R10", n, 0);

    // R10: CE high mid-stream ends the read
    issue_read(8'h00, 8'h10, 8'h23, 8'h01);
    pg = (1 << 8) | 8'h23; col = 16;
    measure_busy(n);
    run_stream(8'h00, pg, col, 2, ended);
    end_read();
    read_byte(v);
    chk("R10", v, exp_byte(pg, 17));

    // R11: reset during page load
    issue_read(8'h00, 8'h05, 8'h10, 8'h02);
    prev = int'(io_out);
    bus_write(1, 8'hFF);
    measure_busy(n);
    read_byte(v);
    chk("R11", v, prev);
    bus_write(0, 8'h01); bus_write(0, 8'h02); bus_write(0, 8'h03);
    hold_ready(LOAD + 4, n);
    chk("R11", n, 0);
    bus_write(1, 8'hFF);
    measure_busy(n);
    chk("R11", n, RSTC);

    // randomised reads
    for (int it = 0; it < 12; it++) begin
      sel = $urandom % 3;
      op = (sel == 0) ? 8'h00 : (sel == 1) ? 8'h01 : 8'h50;
      c1 = $urandom % 256;
      c2 = $urandom % 256;
      c3 = $urandom % 256;
      sel = $urandom % 4;
      if (sel == 0) c2 = (c2 & 8'hE0) | 31;
      else if (sel == 1) c2 = (c2 & 8'hE0) | 30;
      else if (sel == 2) c2 = (c2 & 8'hE0) | 29;
      issue_read(op, c1, c2, c3);
      pg = ((c3 % 128) << 8) | c2;
      col = first_col(op, c1);
      measure_busy(n);
      chk("R6", n, LOAD);
      run_stream(op, pg, col, 200 + ($urandom % 300), ended);
      if (!ended) end_read();
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule